// File: doc/BRIEF.md
# Link Integrity Pulse Monitor

This block keeps watch over the idle-period link integrity of a 10 Mb/s twisted-pair port. On the transmit side it requests a short positive link pulse at a fixed interval, whatever state the link is in. On the receive side it reads single-cycle strobes from the receive path. One strobe marks a qualified link pulse and another marks a completed packet. From these it decides whether the link is passing or failing.

While passing, the block starts a silence timer that any accepted pulse or completed packet restarts. If the timer runs out, the link fails. A failing link blocks data traffic through the fail flag. It recovers on one completed packet, or on a run of closely spaced consecutive pulses, and only once the transmit and receive paths are both idle. Any pulse that follows the last accepted one too soon is discarded. While failing, such a pulse also wipes the run count. A link-test disable input forces the passing state. All timers count a microsecond prescaler tick derived from the 20 MHz system clock.

Top module: `lim_core`

## Requirements
- R1: Synchronous reset (`rst` high) puts the block in the failing state: `link_fail_o` = 1, `link_ok_n_o` = 1, `lp_tx_o` = 0, run count zero, and the pulse spacing timer starts from zero.
- R2: `lp_tx_o` goes high for exactly TX_WIDTH clocks once every TX_PERIOD ticks, with the spacing between rising edges equal to CLK_DIV*TX_PERIOD clocks, in every state.
- R3: While passing, a receive pulse that comes fewer than MIN_GAP ticks after the last accepted pulse is ignored and does not restart the silence timer.
- R4: While passing, FAIL_TIME ticks with neither an accepted pulse nor a completed packet move the block to the failing state.
- R5: While passing, a completed-packet strobe restarts the silence timer.
- R6: While failing, GOOD_PULSES consecutive accepted pulses end the failing state.
- R7: While failing, one completed-packet strobe ends the failing state.
- R8: The failing state is left only in a cycle where `tx_busy_i` and `rx_busy_i` are both low; the exit condition is held until then.
- R9: An accepted pulse that comes more than MAX_GAP ticks after the previous accepted pulse starts a new run with a count of one.
- R10: While failing, a pulse that comes fewer than MIN_GAP ticks after the last accepted pulse clears the run count to zero.
- R11: While `lt_dis_i` is high, the block is held in the passing state from the next clock on.
- R12: `link_ok_n_o` is active low: 0 means passing, 1 means failing, and it always equals `link_fail_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 20 MHz nominal |
| rst | input | 1 | Synchronous active-high reset |
| rx_pulse_i | input | 1 | One-cycle strobe for a qualified received link pulse |
| rx_pkt_done_i | input | 1 | One-cycle strobe for a completed received packet |
| tx_busy_i | input | 1 | Transmit path carrying data |
| rx_busy_i | input | 1 | Receive path carrying data |
| lt_dis_i | input | 1 | Link test disable, forces the passing state |
| lp_tx_o | output | 1 | Transmit link pulse request |
| link_ok_n_o | output | 1 | Link status, low while passing |
| link_fail_o | output | 1 | High while failing, used to gate data traffic |

## Verification
The assertions take the two strobes as single-cycle events. They also assume that the disable input and the busy flags are level signals that change no faster than one clock. The assertions on transmit spacing assume that reset is held long enough for the prescaler and transmit counter to start cleanly. The stimulus raises each strobe for exactly one clock and changes each busy or disable level on a falling edge. It sets pulse spacings well inside the too-close, consecutive or too-far ranges, so that no check depends on the single tick of uncertainty at a window boundary.

// File: rtl/lim_pkg.sv
package lim_pkg;
  typedef enum logic {
    LINK_PASS = 1'b0,
    LINK_FAIL = 1'b1
  } link_st_e;
endpackage

// File: rtl/lim_tick_gen.sv
module lim_tick_gen #(
  parameter int DIV = 20
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/lim_tx_pulse.sv
module lim_tx_pulse #(
  parameter int PERIOD     = 16000,
  parameter int WIDTH_CLKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  output logic pulse_o
);
  localparam int TW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int RW = $clog2(WIDTH_CLKS + 1);
  localparam logic [TW-1:0] T_LAST = TW'(PERIOD - 1);
  localparam logic [RW-1:0] R_LOAD = RW'(WIDTH_CLKS - 1);

  logic [TW-1:0] per_q;
  logic [RW-1:0] rem_q;
  logic          start;

  assign start = tick_i && (per_q == T_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q   <= '0;
      rem_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      if (tick_i) begin
        per_q <= start ? '0 : per_q + 1'b1;
      end
      if (start) begin
        rem_q   <= R_LOAD;
        pulse_o <= 1'b1;
      end else if (rem_q != '0) begin
        rem_q   <= rem_q - 1'b1;
        pulse_o <= 1'b1;
      end else begin
        pulse_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lim_rx_qual.sv
module lim_rx_qual #(
  parameter int MIN_GAP = 4000,
  parameter int MAX_GAP = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic pulse_i,
  output logic accept_o,
  output logic close_o,
  output logic far_o
);
  localparam int GW = $clog2(MAX_GAP + 2);
  localparam logic [GW-1:0] G_MIN = GW'(MIN_GAP);
  localparam logic [GW-1:0] G_MAX = GW'(MAX_GAP);
  localparam logic [GW-1:0] G_SAT = GW'(MAX_GAP + 1);

  logic [GW-1:0] gap_q;

  assign accept_o = pulse_i && (gap_q >= G_MIN);
  assign close_o  = pulse_i && (gap_q <  G_MIN);
  assign far_o    = (gap_q > G_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= '0;
    end else if (accept_o) begin
      gap_q <= '0;
    end else if (tick_i && (gap_q != G_SAT)) begin
      gap_q <= gap_q + 1'b1;
    end
  end
endmodule

// File: rtl/lim_core.sv
module lim_core #(
  parameter int CLK_DIV     = 20,
  parameter int TX_PERIOD   = 16000,
  parameter int TX_WIDTH    = 2,
  parameter int MIN_GAP     = 4000,
  parameter int MAX_GAP     = 100000,
  parameter int FAIL_TIME   = 100000,
  parameter int GOOD_PULSES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_pulse_i,
  input  logic rx_pkt_done_i,
  input  logic tx_busy_i,
  input  logic rx_busy_i,
  input  logic lt_dis_i,
  output logic lp_tx_o,
  output logic link_ok_n_o,
  output logic link_fail_o
);
  import lim_pkg::*;

  localparam int IW = (FAIL_TIME > 1) ? $clog2(FAIL_TIME) : 1;
  localparam int RW = $clog2(GOOD_PULSES + 1);
  localparam logic [IW-1:0] I_LAST = IW'(FAIL_TIME - 1);
  localparam logic [RW-1:0] R_FULL = RW'(GOOD_PULSES);

  logic          tick;
  logic          acc, close, far;
  link_st_e      st_q, st_d;
  logic [RW-1:0] run_q, run_d;
  logic          pkt_q, pkt_d;
  logic [IW-1:0] idle_q, idle_d;

  lim_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  lim_tx_pulse #(.PERIOD(TX_PERIOD), .WIDTH_CLKS(TX_WIDTH)) u_tx (
    .clk(clk), .rst(rst), .tick_i(tick), .pulse_o(lp_tx_o)
  );

  lim_rx_qual #(.MIN_GAP(MIN_GAP), .MAX_GAP(MAX_GAP)) u_rxq (
    .clk(clk), .rst(rst), .tick_i(tick), .pulse_i(rx_pulse_i),
    .accept_o(acc), .close_o(close), .far_o(far)
  );

  always_comb begin
    st_d   = st_q;
    run_d  = run_q;
    pkt_d  = pkt_q;
    idle_d = idle_q;
    if (lt_dis_i) begin
      st_d   = LINK_PASS;
      run_d  = '0;
      pkt_d  = 1'b0;
      idle_d = '0;
    end else if (st_q == LINK_PASS) begin
      if (acc || rx_pkt_done_i) begin
        idle_d = '0;
      end else if (tick) begin
        if (idle_q == I_LAST) begin
          st_d   = LINK_FAIL;
          run_d  = '0;
          pkt_d  = 1'b0;
          idle_d = '0;
        end else begin
          idle_d = idle_q + 1'b1;
        end
      end
    end else begin
      if (((run_q == R_FULL) || pkt_q) && !tx_busy_i && !rx_busy_i) begin
        st_d   = LINK_PASS;
        run_d  = '0;
        pkt_d  = 1'b0;
        idle_d = '0;
      end else begin
        if (close) begin
          run_d = '0;
        end else if (acc) begin
          if ((run_q == '0) || far) begin
            run_d = RW'(1);
          end else if (run_q != R_FULL) begin
            run_d = run_q + 1'b1;
          end
        end
        if (rx_pkt_done_i) begin
          pkt_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= LINK_FAIL;
      run_q       <= '0;
      pkt_q       <= 1'b0;
      idle_q      <= '0;
      link_fail_o <= 1'b1;
      link_ok_n_o <= 1'b1;
    end else begin
      st_q        <= st_d;
      run_q       <= run_d;
      pkt_q       <= pkt_d;
      idle_q      <= idle_d;
      link_fail_o <= (st_d == LINK_FAIL);
      link_ok_n_o <= (st_d != LINK_PASS);
    end
  end
endmodule

// File: rtl/lim_core_chk.sv
module lim_core_chk #(
  parameter int CLK_DIV   = 20,
  parameter int TX_PERIOD = 16000,
  parameter int TX_WIDTH  = 2
) (
  input logic clk,
  input logic rst,
  input logic tx_busy_i,
  input logic rx_busy_i,
  input logic lt_dis_i,
  input logic lp_tx_o,
  input logic link_ok_n_o,
  input logic link_fail_o
);
  localparam int PER_CLKS = CLK_DIV * TX_PERIOD;

  logic prev_tx;
  logic seen_rise;
  int   since_rise;
  int   hi_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_tx    <= 1'b0;
      seen_rise  <= 1'b0;
      since_rise <= 0;
      hi_len     <= 0;
    end else begin
      prev_tx <= lp_tx_o;
      if (lp_tx_o && !prev_tx) begin
        seen_rise  <= 1'b1;
        since_rise <= 1;
      end else if (since_rise < PER_CLKS + 2) begin
        since_rise <= since_rise + 1;
      end
      hi_len <= lp_tx_o ? hi_len + 1 : 0;
    end
  end

  AST_TX_SPACING: assert property (@(posedge clk) disable iff (rst)
    (lp_tx_o && !prev_tx && seen_rise) |-> (since_rise == PER_CLKS)); // R2
  AST_TX_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (!lp_tx_o && prev_tx) |-> (hi_len == TX_WIDTH)); // R2
  AST_STATUS_POLARITY: assert property (@(posedge clk) disable iff (rst)
    link_ok_n_o == link_fail_o); // R12
  AST_DISABLE_PASS: assert property (@(posedge clk) disable iff (rst)
    lt_dis_i |=> !link_fail_o); // R11
  AST_EXIT_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($fell(link_fail_o) && !$past(lt_dis_i)) |-> (!$past(tx_busy_i) && !$past(rx_busy_i))); // R8
  AST_FAIL_NOT_DISABLED: assert property (@(posedge clk) disable iff (rst)
    $rose(link_fail_o) |-> !$past(lt_dis_i)); // R4
endmodule

bind lim_core lim_core_chk #(
  .CLK_DIV(CLK_DIV), .TX_PERIOD(TX_PERIOD), .TX_WIDTH(TX_WIDTH)
) u_chk (
  .clk(clk), .rst(rst), .tx_busy_i(tx_busy_i), .rx_busy_i(rx_busy_i),
  .lt_dis_i(lt_dis_i), .lp_tx_o(lp_tx_o), .link_ok_n_o(link_ok_n_o),
  .link_fail_o(link_fail_o)
);

// File: tb/lim_core_tb.sv
module lim_core_tb;
  localparam int CPT  = 2;
  localparam int TXP  = 10;
  localparam int PW   = 2;
  localparam int MING = 5;
  localparam int MAXG = 30;
  localparam int FT   = 60;
  localparam int GOOD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_pulse = 1'b0, pkt = 1'b0, txb = 1'b0, rxb = 1'b0, dis = 1'b0;
  logic lp_tx, okn, fail;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;

  lim_core #(
    .CLK_DIV(CPT), .TX_PERIOD(TXP), .TX_WIDTH(PW), .MIN_GAP(MING),
    .MAX_GAP(MAXG), .FAIL_TIME(FT), .GOOD_PULSES(GOOD)
  ) u_dut (
    .clk(clk), .rst(rst), .rx_pulse_i(rx_pulse), .rx_pkt_done_i(pkt),
    .tx_busy_i(txb), .rx_busy_i(rxb), .lt_dis_i(dis),
    .lp_tx_o(lp_tx), .link_ok_n_o(okn), .link_fail_o(fail)
  );

  // behavioural reference, evaluated on each rising edge
  int m_pre, m_per, m_rem, m_gap, m_run, m_idle;
  bit m_tx, m_fail, m_pkt;

  always @(posedge clk) begin
    bit tk, go, acc, cls, far, nf, np;
    int nr, ni;
    if (rst) begin
      m_pre = 0; m_per = 0; m_rem = 0; m_tx = 0; m_gap = 0;
      m_fail = 1; m_run = 0; m_pkt = 0; m_idle = 0;
    end else begin
      tk = (m_pre == CPT - 1);
      m_pre = tk ? 0 : m_pre + 1;
      go = tk && (m_per == TXP - 1);
      if (tk) m_per = go ? 0 : m_per + 1;
      if (go) begin m_tx = 1; m_rem = PW - 1; end
      else if (m_rem > 0) begin m_rem--; m_tx = 1; end
      else m_tx = 0;
      acc = rx_pulse && (m_gap >= MING);
      cls = rx_pulse && (m_gap < MING);
      far = (m_gap > MAXG);
      nf = m_fail; nr = m_run; np = m_pkt; ni = m_idle;
      if (dis) begin
        nf = 0; nr = 0; np = 0; ni = 0;
      end else if (!m_fail) begin
        if (acc || pkt) ni = 0;
        else if (tk) begin
          if (m_idle + 1 >= FT) begin nf = 1; nr = 0; np = 0; ni = 0; end
          else ni = m_idle + 1;
        end
      end else begin
        if ((m_run >= GOOD || m_pkt) && !txb && !rxb) begin
          nf = 0; nr = 0; np = 0; ni = 0;
        end else begin
          if (cls) nr = 0;
          else if (acc) nr = (m_run == 0 || far) ? 1 : ((m_run < GOOD) ? m_run + 1 : GOOD);
          if (pkt) np = 1;
        end
      end
      if (acc) m_gap = 0;
      else if (tk && m_gap < MAXG + 1) m_gap++;
      m_fail = nf; m_run = nr; m_pkt = np; m_idle = ni;
    end
  end

  task automatic chk(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-clock comparison and transmit spacing monitor
  int cyc = 0, last_rise = -1, hi_cnt = 0;
  bit prev_l = 0;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk("R2", lp_tx, m_tx, "lp_tx vs model");
      chk(cur_req, fail, m_fail, "link_fail vs model");
      chk("R12", okn, m_fail, "link_ok_n vs model");
      if (lp_tx && !prev_l) begin
        if (last_rise >= 0) chk("R2", (cyc - last_rise) == CPT * TXP, 1'b1, "rise spacing");
        last_rise = cyc;
      end
      if (!lp_tx && prev_l) chk("R2", hi_cnt == PW, 1'b1, "pulse width");
      hi_cnt = lp_tx ? hi_cnt + 1 : 0;
      prev_l = lp_tx;
    end
  end

  task automatic clocks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_pulse();
    rx_pulse = 1'b1; @(negedge clk); rx_pulse = 1'b0;
  endtask

  task automatic strobe_pkt();
    pkt = 1'b1; @(negedge clk); pkt = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clocks(5);
    rst = 1'b0;
    clocks(1);
    // R1: reset state
    chk("R1", fail, 1'b1, "fail after reset");
    chk("R1", okn, 1'b1, "status after reset");
    chk("R1", lp_tx, 1'b0, "tx after reset");

    // R6: four consecutive pulses end the fail state
    cur_req = "R6";
    clocks(20); strobe_pulse();
    clocks(20); strobe_pulse();
    clocks(20); strobe_pulse();
    clocks(4);  chk("R6", fail, 1'b1, "fail after three pulses");
    clocks(16); strobe_pulse();
    clocks(4);  chk("R6", fail, 1'b0, "pass after four pulses");
    chk("R12", okn, 1'b0, "status low while passing");

    // R3: too-close pulse in pass does not restart the silence timer
    cur_req = "R3";
    clocks(20); strobe_pulse();
    clocks(8);  strobe_pulse();
    clocks(92); chk("R4", fail, 1'b0, "still passing before timeout");
    clocks(23); chk("R3", fail, 1'b1, "timeout measured from accepted pulse");

    // R8 / R7: packet exit waits for idle transmit
    cur_req = "R7";
    txb = 1'b1;
    strobe_pkt();
    clocks(10); chk("R8", fail, 1'b1, "held while transmit busy");
    txb = 1'b0;
    clocks(4);  chk("R7", fail, 1'b0, "pass after one packet");

    // R5: packets keep the link passing
    cur_req = "R5";
    for (int i = 0; i < 3; i++) begin
      clocks(80); strobe_pkt();
    end
    chk("R5", fail, 1'b0, "packets restart silence timer");
    cur_req = "R4";
    clocks(130); chk("R4", fail, 1'b1, "fail after silence");

    // R10: too-close pulse in fail clears the run
    cur_req = "R10";
    strobe_pulse();
    clocks(20); strobe_pulse();
    clocks(20); strobe_pulse();
    clocks(4);  strobe_pulse();
    clocks(16); strobe_pulse();
    clocks(20); strobe_pulse();
    clocks(20); strobe_pulse();
    clocks(4);  chk("R10", fail, 1'b1, "run restarted after close pulse");
    clocks(16); strobe_pulse();
    clocks(4);  chk("R6", fail, 1'b0, "pass after rebuilt run");

    // R9: far pulse starts a new run; R8 with receive busy
    cur_req = "R9";
    clocks(130); chk("R4", fail, 1'b1, "fail again");
    strobe_pulse();
    clocks(20); strobe_pulse();
    clocks(20); strobe_pulse();
    clocks(80); strobe_pulse();
    clocks(20); strobe_pulse();
    clocks(20); strobe_pulse();
    clocks(4);  chk("R9", fail, 1'b1, "far pulse restarted run");
    rxb = 1'b1;
    clocks(16); strobe_pulse();
    clocks(6);  chk("R8", fail, 1'b1, "held while receive busy");
    rxb = 1'b0;
    clocks(4);  chk("R9", fail, 1'b0, "pass after new run completes");

    // R11: disable forces passing
    cur_req = "R11";
    clocks(130); chk("R4", fail, 1'b1, "fail before disable");
    dis = 1'b1;
    clocks(3);   chk("R11", fail, 1'b0, "pass under disable");
    chk("R11", okn, 1'b0, "status low under disable");
    clocks(200); chk("R11", fail, 1'b0, "stays passing under disable");
    dis = 1'b0;
    cur_req = "R4";
    clocks(130); chk("R4", fail, 1'b1, "fail after disable released");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule